// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins, eight by default, and raises one interrupt request line per pin. Software picks a trigger condition for each pin on its own. The choices are a low level, any change of level, a falling edge or a rising edge. Each pin first passes through a synchronizer. Edges are then found by comparing two successive clocked samples of the synchronized value.

Edge-type triggers set a sticky flag for their channel. Level triggers do not use the flag: the request simply follows the pin while it is held low. A flag is cleared in one of two ways. Software can write a one to the flag's bit, or the interrupt sequencer can acknowledge the channel. A per-channel mask and a single global enable decide which requests reach the outputs. The lower channels do not support the any-change trigger: that code never fires on them.

Top module: `ext_irq_sense`

## Requirements
- R1: Sense code 0 (low level) drives the channel's request from the synchronized pin directly. The request rises two clock edges after the pin goes low and stays high while the pin is low. This mode never sets the flag.
- R2: Sense code 1 (any change) is honoured on channels at index LOW_CH (4) and above. A change of the sample in either direction sets the flag.
- R3: Sense code 2 (falling) sets the flag when the newer sample is 0 and the older sample is 1. The flag becomes readable three clock edges after the pin changes. It stays set after the pin returns high.
- R4: Sense code 3 (rising) sets the flag when the older sample is 0 and the newer sample is 1.
- R5: On channels below LOW_CH, sense code 1 never sets the flag.
- R6: In any mode other than code 0, a channel's request follows its flag. A request reaches irq_o only when the global enable and the channel's mask bit are both 1.
- R7: Writing to the flag register (address 2) clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: A high ack_i bit clears that channel's flag at the next clock edge.
- R9: An edge detected in the same cycle as a software clear or an acknowledge wins, and the flag stays set.
- R10: After reset every register and flag reads zero, every channel is in low-level mode, and irq_o is all zero.
- R11: The register map is as follows. Address 0 holds the sense codes, with channel n's code in bits [2n+1:2n]. Address 1 holds the mask, bit n for channel n. Address 2 holds the flags. Address 3 holds the global enable in bit 0. Reads are combinational and zero-extended.
- R12: A pin pulse lasting one full clock period sets the flag in edge or any-change mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_CH | External interrupt pins, asynchronous |
| ack_i | input | NUM_CH | Per-channel acknowledge from the sequencer, clears the flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*NUM_CH | Register write data |
| reg_rdata | output | 2*NUM_CH | Register read data, combinational |
| irq_o | output | NUM_CH | Gated per-channel interrupt requests |

## Verification
The assertions assume that pins, acknowledges and register writes change only between clock edges and are free of X after reset. The bench drives every input on the falling edge to meet this. The assertions place no limit on how a software clear, an acknowledge and a new edge overlap. The random stimulus therefore lets all three collide freely, while writes to the sense field may land at any time, including while a channel is active.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_ANY  = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_RISE = 2'd3
    } sense_e;

    localparam logic [1:0] ADDR_SENSE = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;
    localparam logic [1:0] ADDR_GIE   = 2'd3;

    typedef struct packed {
        logic prev;
        logic flag;
    } chan_state_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int NUM_CH = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] sync_o
);

    logic [STAGES-1:0][NUM_CH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [1:0]            addr_i,
    input  logic [2*NUM_CH-1:0]   wdata_i,
    input  logic [NUM_CH-1:0]     flags_i,
    output logic [2*NUM_CH-1:0]   rdata_o,
    output logic [2*NUM_CH-1:0]   sense_o,
    output logic [NUM_CH-1:0]     mask_o,
    output logic                  gie_o,
    output logic [NUM_CH-1:0]     clr_o
);

    localparam int DW = 2 * NUM_CH;

    typedef struct packed {
        logic [DW-1:0]     sense;
        logic [NUM_CH-1:0] mask;
        logic              gie;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (we_i) begin
            unique case (addr_i)
                ADDR_SENSE: st_d.sense = wdata_i;
                ADDR_MASK:  st_d.mask  = wdata_i[NUM_CH-1:0];
                ADDR_FLAG:  clr_o      = wdata_i[NUM_CH-1:0];
                ADDR_GIE:   st_d.gie   = wdata_i[0];
                default:    st_d       = st_q;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_SENSE: rdata_o = st_q.sense;
            ADDR_MASK:  rdata_o = {{(DW-NUM_CH){1'b0}}, st_q.mask};
            ADDR_FLAG:  rdata_o = {{(DW-NUM_CH){1'b0}}, flags_i};
            ADDR_GIE:   rdata_o = {{(DW-1){1'b0}}, st_q.gie};
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sense_o = st_q.sense;
    assign mask_o  = st_q.mask;
    assign gie_o   = st_q.gie;

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
#(
    parameter bit NO_ANY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sense_i,
    input  logic       cur_i,
    input  logic       mask_i,
    input  logic       gie_i,
    input  logic       clr_i,
    input  logic       ack_i,
    output logic       prev_o,
    output logic       flag_o,
    output logic       irq_o
);

    chan_state_t st_d, st_q;
    logic        hit;
    logic        req;
    sense_e      mode;

    assign mode = sense_e'(sense_i);

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_i;
        unique case (mode)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = NO_ANY ? 1'b0 : (cur_i ^ st_q.prev);
            SENSE_FALL: hit = st_q.prev & ~cur_i;
            SENSE_RISE: hit = ~st_q.prev & cur_i;
            default:    hit = 1'b0;
        endcase
        if (hit)                 st_d.flag = 1'b1;
        else if (clr_i || ack_i) st_d.flag = 1'b0;
        req = (mode == SENSE_LOW) ? ~cur_i : st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_o = st_q.prev;
    assign flag_o = st_q.flag;
    assign irq_o  = gie_i & mask_i & req;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
    parameter int NUM_CH      = 8,
    parameter int LOW_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   pin_i,
    input  logic [NUM_CH-1:0]   ack_i,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [2*NUM_CH-1:0] reg_wdata,
    output logic [2*NUM_CH-1:0] reg_rdata,
    output logic [NUM_CH-1:0]   irq_o
);

    logic [NUM_CH-1:0]   sync_w;
    logic [NUM_CH-1:0]   prev_w;
    logic [NUM_CH-1:0]   flag_w;
    logic [NUM_CH-1:0]   mask_w;
    logic [NUM_CH-1:0]   clr_w;
    logic [2*NUM_CH-1:0] sense_w;
    logic                gie_w;

    ext_irq_sync #(
        .NUM_CH (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (sync_w)
    );

    ext_irq_regs #(
        .NUM_CH (NUM_CH)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .flags_i (flag_w),
        .rdata_o (reg_rdata),
        .sense_o (sense_w),
        .mask_o  (mask_w),
        .gie_o   (gie_w),
        .clr_o   (clr_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ext_irq_chan #(
            .NO_ANY (g < LOW_CH)
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sense_i (sense_w[2*g +: 2]),
            .cur_i   (sync_w[g]),
            .mask_i  (mask_w[g]),
            .gie_i   (gie_w),
            .clr_i   (clr_w[g]),
            .ack_i   (ack_i[g]),
            .prev_o  (prev_w[g]),
            .flag_o  (flag_w[g]),
            .irq_o   (irq_o[g])
        );
    end

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
    parameter int NUM_CH = 8,
    parameter int LOW_CH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_CH-1:0] sense,
    input logic [NUM_CH-1:0]   cur,
    input logic [NUM_CH-1:0]   prev,
    input logic [NUM_CH-1:0]   flag,
    input logic [NUM_CH-1:0]   mask,
    input logic                gie,
    input logic [NUM_CH-1:0]   irq
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (gie && mask[i]));

        p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[2*i +: 2] == 2'd0 && gie && mask[i]) |-> (irq[i] == !cur[i]));

        p_level_noflag_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[2*i +: 2] == 2'd0 && !flag[i]) |=> !flag[i]);

        p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[2*i +: 2] == 2'd2 && prev[i] && !cur[i]) |=> flag[i]);

        p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[2*i +: 2] == 2'd3 && !prev[i] && cur[i]) |=> flag[i]);

        if (i < LOW_CH) begin : g_low
            p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sense[2*i +: 2] == 2'd1 && !flag[i]) |=> !flag[i]);
        end else begin : g_high
            p_any_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (sense[2*i +: 2] == 2'd1 && (prev[i] != cur[i])) |=> flag[i]);
        end
    end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(
    .NUM_CH (NUM_CH),
    .LOW_CH (LOW_CH)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sense (sense_w),
    .cur   (sync_w),
    .prev  (prev_w),
    .flag  (flag_w),
    .mask  (mask_w),
    .gie   (gie_w),
    .irq   (irq_o)
);

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;

    localparam int N  = 8;
    localparam int LO = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   pin;
    logic [N-1:0]   ack;
    logic           we;
    logic [1:0]     addr;
    logic [2*N-1:0] wdata;
    logic [2*N-1:0] rdata;
    logic [N-1:0]   irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ext_irq_sense #(.NUM_CH(N), .LOW_CH(LO), .SYNC_STAGES(2)) i_ext_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .ack_i(ack), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    // Bench model built from the requirements
    logic [N-1:0]   m_s1, m_s2, m_prev, m_flag, m_mask;
    logic [2*N-1:0] m_sense;
    logic           m_gie;

    function automatic logic hit_of(int ch, logic [1:0] code, logic p, logic c);
        case (code)
            2'd1:    return (ch >= LO) ? (p != c) : 1'b0;
            2'd2:    return p & ~c;
            2'd3:    return ~p & c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] r;
        for (int c = 0; c < N; c++) begin
            logic req;
            req  = (m_sense[2*c +: 2] == 2'd0) ? ~m_s2[c] : m_flag[c];
            r[c] = m_gie & m_mask[c] & req;
        end
        return r;
    endfunction

    function automatic string tag_of(int ch);
        case (m_sense[2*ch +: 2])
            2'd0:    return "R1";
            2'd1:    return (ch >= LO) ? "R2" : "R5";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0;
            m_mask <= '0; m_sense <= '0; m_gie <= 1'b0;
        end else begin
            for (int c = 0; c < N; c++) begin
                logic clr;
                clr = ack[c] | (we && addr == 2'd2 && wdata[c]);
                if (hit_of(c, m_sense[2*c +: 2], m_prev[c], m_s2[c])) m_flag[c] <= 1'b1;
                else if (clr) m_flag[c] <= 1'b0;
            end
            m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin;
            if (we && addr == 2'd0) m_sense <= wdata;
            if (we && addr == 2'd1) m_mask  <= wdata[N-1:0];
            if (we && addr == 2'd3) m_gie   <= wdata[0];
        end
    end

    // Continuous comparison of irq_o, sampled after the edge settles
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [N-1:0] e;
            e = exp_irq();
            checks++;
            if (irq !== e) begin
                errors++;
                for (int c = 0; c < N; c++)
                    if (irq[c] !== e[c])
                        $display("FAIL %s irq ch%0d actual %b expected %b", tag_of(c), c, irq[c], e[c]);
            end
        end
    end

    task automatic chk(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [2*N-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [2*N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pin = '1; ack = '0; we = 1'b0; addr = '0; wdata = '0;
        step(3);
        rst_n = 1'b1;
        step(3);

        // R10 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R10 reset readback", v, '0);
        end
        chk("R10 irq after reset", {{N{1'b0}}, irq}, '0);

        // R11 register map readback
        wr(2'd1, 16'h00ff);
        wr(2'd3, 16'h0001);
        rd(2'd1, v); chk("R11 mask readback", v, 16'h00ff);
        rd(2'd3, v); chk("R11 gie readback", v, 16'h0001);
        wr(2'd0, 16'h00a0);
        rd(2'd0, v); chk("R11 sense readback", v, 16'h00a0);
        wr(2'd0, 16'h0000);

        // R1 level mode on ch0: request after two edges, no flag
        step(3);
        @(negedge clk); pin[0] = 1'b0;
        step(1); chk("R1 level not yet", {15'b0, irq[0]}, 16'h0);
        step(1); chk("R1 level active", {15'b0, irq[0]}, 16'h1);
        step(5); chk("R1 level held", {15'b0, irq[0]}, 16'h1);
        rd(2'd2, v); chk("R1 no flag", v, 16'h0);
        pin[0] = 1'b1; step(3);

        // R3 falling on ch4 (code 2 at bits 9:8)
        wr(2'd0, 16'h0200);
        step(3);
        @(negedge clk); pin[4] = 1'b0;
        step(2); rd(2'd2, v); chk("R3 flag not yet", v, 16'h0);
        step(1); rd(2'd2, v); chk("R3 flag set", v, 16'h0010);
        chk("R6 irq follows flag", {8'b0, irq}, 16'h0010);
        pin[4] = 1'b1; step(4);
        rd(2'd2, v); chk("R3 flag persists", v, 16'h0010);

        // R6 gating
        wr(2'd1, 16'h00ef); chk("R6 mask blocks", {8'b0, irq}, 16'h0);
        wr(2'd1, 16'h00ff); wr(2'd3, 16'h0000);
        chk("R6 gie blocks", {8'b0, irq}, 16'h0);
        wr(2'd3, 16'h0001);

        // R7 write-one-to-clear
        wr(2'd2, 16'h00ef); rd(2'd2, v); chk("R7 zero no effect", v, 16'h0010);
        wr(2'd2, 16'h0010); rd(2'd2, v); chk("R7 one clears", v, 16'h0);

        // R4 rising on ch6 (bits 13:12) and R12 one-cycle pulse
        wr(2'd0, 16'h3000);
        @(negedge clk); pin[6] = 1'b0;
        step(4);
        wr(2'd2, 16'h0040);
        @(negedge clk); pin[6] = 1'b1;
        @(negedge clk); pin[6] = 1'b0;
        step(2); rd(2'd2, v); chk("R12 short pulse flag", v, 16'h0040);
        chk("R4 rising irq", {8'b0, irq}, 16'h0040);

        // R8 acknowledge clears
        @(negedge clk); ack[6] = 1'b1;
        @(negedge clk); ack[6] = 1'b0;
        rd(2'd2, v); chk("R8 ack clears", v, 16'h0);

        // R5 reserved code on ch1, R2 any change on ch5
        wr(2'd0, 16'h0404);
        @(negedge clk); pin[1] = 1'b0; pin[5] = 1'b0;
        step(4); rd(2'd2, v); chk("R2 any change fall", v, 16'h0020);
        wr(2'd2, 16'h0020);
        @(negedge clk); pin[1] = 1'b1; pin[5] = 1'b1;
        step(4); rd(2'd2, v); chk("R2 any change rise", v, 16'h0020);
        chk("R5 reserved silent", {15'b0, irq[1]}, 16'h0);

        // R9 new edge collides with software clear and with ack
        @(negedge clk); pin[5] = 1'b0;
        step(2);
        we = 1'b1; addr = 2'd2; wdata = 16'h0020;
        step(1); we = 1'b0;
        rd(2'd2, v); chk("R9 edge beats clear", v, 16'h0020);
        @(negedge clk); pin[5] = 1'b1;
        step(2);
        ack[5] = 1'b1;
        step(1); ack[5] = 1'b0;
        rd(2'd2, v); chk("R9 edge beats ack", v, 16'h0020);

        // Random phase, checked by the model comparison
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            for (int c = 0; c < N; c++)
                if ($urandom % 6 == 0) pin[c] = ~pin[c];
            ack = '0;
            for (int c = 0; c < N; c++)
                if ($urandom % 10 == 0) ack[c] = 1'b1;
            we = 1'b0;
            if ($urandom % 12 == 0) begin
                we    = 1'b1;
                addr  = 2'($urandom % 4);
                wdata = 16'($urandom);
                if (addr == 2'd3 && ($urandom % 4 != 0)) wdata[0] = 1'b1;
            end else begin
                addr = 2'd2;
                #1;
                chk("R7 flag model", rdata, {8'b0, m_flag});
            end
        end
        @(negedge clk); we = 1'b0; ack = '0;
        step(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule